// File: doc/BRIEF.md
# Oblique Node Evaluator with Rounding-Error Flag

This block evaluates a single oblique split of a fixed-point decision tree. It receives an attribute vector and the node's weight vector with a bias term. It forms the weighted sum one product per cycle and rounds every product toward negative infinity. From the sign of the result it picks the branch: the left child when the sum is zero or positive, the right child otherwise.

The rounded sum is never above the exact sum. Because of this, the block also forms an upper estimate by adding a per-model bound to it. That bound is held in a loadable register and is normally the multiplication count times one LSB. When the rounded sum and the upper estimate fall on opposite sides of zero, a potential-error flag is raised. The flag marks that finite precision may have steered the vector to the wrong child.

A request is accepted with a start pulse. The vectors are latched, and a one-cycle done pulse presents the decision, the sum and the flag, which then hold until the next result.

Top module: `oblique_node_eval`

## Requirements
- R1: All values are signed Q11.5 (16 bits). Attribute k sits in `attr_i[16k+15:16k]`, weight k in `coef_i[16k+15:16k]`, and the bias in the top 16 bits of `coef_i`. The result `sum_o` equals the bias plus, for each k, floor(weight_k × attr_k / 32).
- R2: `go_left_o` is 1 when the reported sum is greater than or equal to zero, and 0 when it is negative.
- R3: `err_o` is 1 exactly when the sign of `sum_o` differs from the sign of `sum_o` plus the sign-extended bound register.
- R4: `done_o` is a single-cycle pulse. It rises N_ATTR clock cycles after the edge that accepts `start_i`. `sum_o`, `go_left_o` and `err_o` hold their values until the next pulse.
- R5: A `start_i` raised while an evaluation is in progress is ignored. The running result uses the vectors latched at acceptance.
- R6: The bound register loads `bound_i` on a clock edge with `bound_load_i` high and otherwise keeps its value. After reset it holds N_ATTR (N_ATTR LSBs).
- R7: During and after reset, `done_o`, `go_left_o` and `err_o` are 0 and `sum_o` is 0.
- R8: With the bound at N_ATTR, `err_o` is never 0 when the branch chosen by the all-floor sum differs from the branch chosen by the all-ceiling sum.
- R9: The accumulator never wraps. Full-scale extreme operands in every lane give the exact mathematical result of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse; accepted when idle |
| attr_i | input | N_ATTR*16 | Attribute vector, Q11.5 lanes |
| coef_i | input | (N_ATTR+1)*16 | Weight lanes, bias in top lane |
| bound_load_i | input | 1 | Load strobe for the rounding bound |
| bound_i | input | 16 | New rounding bound, signed LSB units |
| done_o | output | 1 | Result-valid pulse |
| go_left_o | output | 1 | 1 = left child, 0 = right child |
| sum_o | output | 27+clog2(N_ATTR+1) | Rounded-down node sum, Q.5 signed |
| err_o | output | 1 | Potential misrouting flag |

## Verification
The results are due N_ATTR cycles after the accepting edge: one accumulation edge per lane, and the last one also registers the outputs. Each scenario raises start on a falling edge and then counts falling edges until `done_o` is seen. It requires that count to equal N_ATTR and compares the outputs at that falling edge. One falling edge later it confirms that the pulse has dropped while the values still hold. The expected sum comes from exact integer floor and ceiling arithmetic. The flag is judged against both the bound rule and the floor-versus-ceiling branch disagreement.

// File: rtl/one_node_pkg.sv
package one_node_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/node_seq.sv
module node_seq #(
  parameter int N_ATTR = 4,
  localparam int IDX_W = (N_ATTR > 1) ? $clog2(N_ATTR) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             acc_en_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o
);
  import one_node_pkg::*;

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_ATTR - 1);

  seq_state_e state_q;
  logic [IDX_W-1:0] idx_q;

  assign load_o   = (state_q == ST_IDLE) && start_i;
  assign acc_en_o = (state_q == ST_RUN);
  assign last_o   = acc_en_o && (idx_q == IDX_LAST);
  assign idx_o    = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else if (load_o) begin
      state_q <= ST_RUN;
      idx_q   <= '0;
    end else if (acc_en_o) begin
      if (last_o) state_q <= ST_IDLE;
      idx_q <= last_o ? '0 : idx_q + 1'b1;
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_en_o |-> (idx_q <= IDX_LAST)); // R4
  AST_RUN_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (state_q == ST_IDLE)); // R4
endmodule

// File: rtl/node_mac.sv
module node_mac #(
  parameter int N_ATTR = 4,
  parameter int W      = 16,
  parameter int FRAC   = 5,
  localparam int IDX_W = (N_ATTR > 1) ? $clog2(N_ATTR) : 1,
  localparam int PROD_W = 2 * W,
  localparam int RED_W  = PROD_W - FRAC,
  localparam int SUM_W  = RED_W + $clog2(N_ATTR + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic                    acc_en_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [N_ATTR*W-1:0]     attr_i,
  input  logic [(N_ATTR+1)*W-1:0] coef_i,
  output logic signed [SUM_W-1:0] acc_nxt_o
);
  logic [N_ATTR*W-1:0] attr_q;
  logic [N_ATTR*W-1:0] wgt_q;
  logic signed [SUM_W-1:0] acc_q;

  logic signed [W-1:0]      a_sel, w_sel;
  logic signed [PROD_W-1:0] prod;
  logic signed [RED_W-1:0]  prod_dn;
  logic signed [W-1:0]      bias;

  assign bias   = $signed(coef_i[N_ATTR*W +: W]);
  assign a_sel  = $signed(attr_q[idx_i*W +: W]);
  assign w_sel  = $signed(wgt_q[idx_i*W +: W]);
  assign prod   = a_sel * w_sel;
  // floor rounding: drop fraction bits of the Q22.10 product
  assign prod_dn = prod[PROD_W-1:FRAC];
  assign acc_nxt_o = acc_q + SUM_W'(prod_dn);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      attr_q <= '0;
      wgt_q  <= '0;
      acc_q  <= '0;
    end else if (load_i) begin
      attr_q <= attr_i;
      wgt_q  <= coef_i[N_ATTR*W-1:0];
      acc_q  <= SUM_W'(bias);
    end else if (acc_en_i) begin
      acc_q <= acc_nxt_o;
    end
  end

  AST_NO_WRAP_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && !acc_q[SUM_W-1] && !prod_dn[RED_W-1]) |-> !acc_nxt_o[SUM_W-1]); // R9
  AST_NO_WRAP_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && acc_q[SUM_W-1] && prod_dn[RED_W-1]) |-> acc_nxt_o[SUM_W-1]); // R9
  AST_OPERANDS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && !load_i) |=> $stable(attr_q) && $stable(wgt_q)); // R5
endmodule

// File: rtl/err_detect.sv
module err_detect #(
  parameter int W     = 16,
  parameter int SUM_W = 30
) (
  input  logic signed [SUM_W-1:0] sum_dn_i,
  input  logic signed [W-1:0]     bound_i,
  output logic                    go_left_o,
  output logic                    err_o
);
  logic signed [SUM_W-1:0] sum_up;

  assign sum_up    = sum_dn_i + SUM_W'(bound_i);
  assign go_left_o = !sum_dn_i[SUM_W-1];
  assign err_o     = sum_dn_i[SUM_W-1] ^ sum_up[SUM_W-1];
endmodule

// File: rtl/oblique_node_eval.sv
module oblique_node_eval #(
  parameter int N_ATTR = 4,
  parameter int W      = 16,
  parameter int FRAC   = 5,
  localparam int IDX_W = (N_ATTR > 1) ? $clog2(N_ATTR) : 1,
  localparam int SUM_W = 2 * W - FRAC + $clog2(N_ATTR + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [N_ATTR*W-1:0]     attr_i,
  input  logic [(N_ATTR+1)*W-1:0] coef_i,
  input  logic                    bound_load_i,
  input  logic [W-1:0]            bound_i,
  output logic                    done_o,
  output logic                    go_left_o,
  output logic [SUM_W-1:0]        sum_o,
  output logic                    err_o
);
  logic             load, acc_en, last;
  logic [IDX_W-1:0] idx;
  logic signed [SUM_W-1:0] acc_nxt;
  logic [W-1:0] bound_q;
  logic left_c, err_c;
  logic done_q, left_q, err_q;
  logic [SUM_W-1:0] sum_q;

  node_seq #(.N_ATTR(N_ATTR)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .load_o(load), .acc_en_o(acc_en), .last_o(last), .idx_o(idx)
  );

  node_mac #(.N_ATTR(N_ATTR), .W(W), .FRAC(FRAC)) u_mac (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .acc_en_i(acc_en),
    .idx_i(idx), .attr_i(attr_i), .coef_i(coef_i), .acc_nxt_o(acc_nxt)
  );

  err_detect #(.W(W), .SUM_W(SUM_W)) u_err (
    .sum_dn_i(acc_nxt), .bound_i($signed(bound_q)),
    .go_left_o(left_c), .err_o(err_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bound_q <= W'(N_ATTR);
    else if (bound_load_i) bound_q <= bound_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      left_q <= 1'b0;
      err_q  <= 1'b0;
      sum_q  <= '0;
    end else begin
      done_q <= last;
      if (last) begin
        sum_q  <= acc_nxt;
        left_q <= left_c;
        err_q  <= err_c;
      end
    end
  end

  assign done_o    = done_q;
  assign go_left_o = left_q;
  assign sum_o     = sum_q;
  assign err_o     = err_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last |=> $stable(sum_o) && $stable(err_o) && $stable(go_left_o)); // R4
  AST_LEFT_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (go_left_o != sum_o[SUM_W-1])); // R2
  AST_FLAG_NEG_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o && !bound_q[W-1]) |-> sum_o[SUM_W-1]); // R3
  AST_BOUND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bound_load_i |=> $stable(bound_q)); // R6
  AST_DONE_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(acc_en)); // R4
endmodule

// File: tb/oblique_node_eval_test.sv
`timescale 1ns/1ps
module oblique_node_eval_test;
  localparam int N = 4;
  localparam int W = 16;
  localparam int SUM_W = 2 * W - 5 + $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N*W-1:0] attr = '0;
  logic [(N+1)*W-1:0] coef = '0;
  logic bound_load = 1'b0;
  logic [W-1:0] bound = '0;
  logic done, go_left, err;
  logic [SUM_W-1:0] sum;

  int total = 0;
  int bad = 0;
  longint bound_cur = N;
  logic [31:0] lcg = 32'h1234_5678;

  always #2 clk = ~clk;

  oblique_node_eval #(.N_ATTR(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .attr_i(attr), .coef_i(coef),
    .bound_load_i(bound_load), .bound_i(bound), .done_o(done),
    .go_left_o(go_left), .sum_o(sum), .err_o(err)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint lane(input logic [(N+1)*W-1:0] v, input int k);
    return longint'($signed(v[k*W +: W]));
  endfunction

  function automatic logic [15:0] rnd16();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[30:15];
  endfunction

  task automatic load_bound(input logic [W-1:0] b);
    @(negedge clk);
    bound = b; bound_load = 1'b1;
    @(negedge clk);
    bound_load = 1'b0;
    bound_cur = longint'($signed(b));
  endtask

  // run one evaluation; optionally disturb with a second start mid-run
  task automatic run_node(input logic [N*W-1:0] a, input logic [(N+1)*W-1:0] c,
                          input bit disturb);
    longint s_dn, s_up_exact, p, fl, ce, up;
    bit exp_err;
    int cnt;
    logic [SUM_W-1:0] held;
    s_dn = lane(c, N);
    s_up_exact = lane(c, N);
    for (int k = 0; k < N; k++) begin
      p  = lane({16'h0, a}, k) * lane(c, k);
      fl = p >>> 5;
      ce = -((-p) >>> 5);
      s_dn += fl;
      s_up_exact += ce;
    end
    up = s_dn + bound_cur;
    exp_err = (s_dn < 0) != (up < 0);
    @(negedge clk);
    attr = a; coef = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 40) begin
      if (disturb && cnt == 1) begin
        attr = ~a; coef = ~c; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    check("R4 latency", cnt, N);
    check("R1 sum", longint'($signed(sum)), s_dn);
    check("R2 go_left", longint'(go_left), longint'(s_dn >= 0));
    check("R3 err", longint'(err), longint'(exp_err));
    if (bound_cur == N && ((s_dn >= 0) != (s_up_exact >= 0)))
      check("R8 flag on split", longint'(err), 1);
    held = sum;
    @(negedge clk);
    check("R4 done pulse", longint'(done), 0);
    check("R4 hold", longint'($signed(sum)), longint'($signed(held)));
  endtask

  task automatic t_reset();
    check("R7 done", longint'(done), 0);
    check("R7 sum", longint'($signed(sum)), 0);
    check("R7 err", longint'(err), 0);
    check("R7 left", longint'(go_left), 0);
  endtask

  task automatic t_basic();
    // 1.0*2.0 + 0.5*(-1.0) + 0 + 0 + bias 0.25
    run_node({16'd0, 16'd0, 16'hFFE0, 16'd64},
             {16'd8, 16'd0, 16'd0, 16'd16, 16'd32}, 1'b0);
    // exact negative: -1.0 * 1.0 in all lanes
    run_node({4{16'd32}}, {16'd0, {4{16'hFFE0}}}, 1'b0);
    // all zero -> sum 0, left
    run_node('0, '0, 1'b0);
  endtask

  task automatic t_split();
    // each product 1/1024: floor 0, ceil 1; bias -1 LSB -> split, R8
    run_node({4{16'd1}}, {16'hFFFF, {4{16'd1}}}, 1'b0);
    // negative tiny products: floor -1 each, bias +3 -> sum -1, ceil 3
    run_node({4{16'hFFFF}}, {16'd3, {4{16'd1}}}, 1'b0);
  endtask

  task automatic t_extreme();
    run_node({4{16'h8000}}, {16'h7FFF, {4{16'h8000}}}, 1'b0); // R9
    run_node({4{16'h8000}}, {16'h8000, {4{16'h7FFF}}}, 1'b0); // R9
  endtask

  task automatic t_busy_start();
    run_node({16'd40, 16'd3, 16'hFF00, 16'd7},
             {16'hFFF0, 16'd5, 16'd9, 16'hFFFB, 16'd100}, 1'b1); // R5
  endtask

  task automatic t_bound();
    load_bound(16'd0); // R6: zero bound never flags
    run_node({4{16'd1}}, {16'hFFFF, {4{16'd1}}}, 1'b0);
    load_bound(16'd200); // R6: wide bound
    run_node({16'd0, 16'd0, 16'd0, 16'd32}, {16'hFF00, 16'd0, 16'd0, 16'd0, 16'd32}, 1'b0);
    load_bound(16'(N));
  endtask

  task automatic t_random();
    logic [N*W-1:0] a;
    logic [(N+1)*W-1:0] c;
    for (int r = 0; r < 40; r++) begin
      for (int k = 0; k < N; k++) begin
        a[k*W +: W] = 16'($signed(rnd16()) >>> 4);
        c[k*W +: W] = 16'($signed(rnd16()) >>> 8);
      end
      c[N*W +: W] = 16'($signed(rnd16()) >>> 6);
      run_node(a, c, 1'b0); // R1 R2 R3 R8
    end
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_split();
    t_extreme();
    t_busy_start();
    t_bound();
    t_random();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule